// File: doc/BRIEF.md
# Battery-Backed SRAM Access Guard

This block sits between a host bus and an external static RAM of up to 512 KB. Each host access carries a 19-bit byte address and active-low chip enable, write enable and output enable. The block either passes the access through to the external RAM or routes it to a sixteen-entry internal register file. That register file always occupies the highest sixteen byte addresses, whatever size of RAM is fitted. While a register is being accessed, the RAM output enable and write enable are held inactive. This lets the registers overlay the top of a continuous RAM map with no bus contention and no shadow write into the RAM cells underneath.

A supply-status input reports whether the supply is within tolerance. While it is not, every RAM strobe is forced inactive and register writes are discarded. When the supply recovers, access is re-enabled only after the host chip enable has been seen inactive at one clock edge. This keeps a half-finished cycle from resuming. All RAM strobes, register read data and the read-valid flag are registered, so each is due one clock after the inputs that cause it.

Top module: `bbram_guard`

## Requirements
- R1: While reset is held, `ram_ce_n`, `ram_oe_n` and `ram_we_n` are 1 and `reg_rvalid` is 0.
- R2: Outside the register window, with the supply good and access enabled, one cycle after the host inputs the outputs are as follows. `ram_ce_n` equals `host_ce_n`. `ram_oe_n` is 0 only when `host_ce_n` and `host_oe_n` are both 0. `ram_we_n` is 0 only when `host_ce_n` and `host_we_n` are both 0.
- R3: The register window is every address whose bits 18 down to 4 are all ones (7FFF0h to 7FFFFh). For a selected access inside the window, `ram_oe_n` is 1 on the next cycle, and `ram_ce_n` follows `host_ce_n`.
- R4: A write inside the window leaves `ram_we_n` at 1. A write outside the window never changes a register, even when its low four address bits match.
- R5: A write with `host_ce_n`=0 and `host_we_n`=0 inside the window stores `host_wdata` into register `host_addr[3:0]` at the clock edge. A later read from that address returns the stored byte on `reg_rdata`.
- R6: `reg_rvalid` is 1 one cycle after an access that is inside the window, has `host_ce_n`=0, `host_oe_n`=0 and `host_we_n`=1, and finds access enabled. Otherwise `reg_rvalid` is 0.
- R7: When `supply_ok` is 0 at a clock edge, all three RAM strobes are 1 and `reg_rvalid` is 0 on the next cycle.
- R8: A register write presented while `supply_ok` is 0 is discarded, and the register keeps its value.
- R9: After `supply_ok` returns to 1, the RAM strobes stay at 1 until an edge with `supply_ok`=1 and `host_ce_n`=1 has passed. Host strobes take effect from the following edge. The same re-arm applies after reset.
- R10: All sixteen registers hold independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 19 | Host byte address |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_wdata | input | 8 | Host write data for the register file |
| supply_ok | input | 1 | 1 when the supply is within tolerance |
| ram_ce_n | output | 1 | External RAM chip enable, active low, registered |
| ram_oe_n | output | 1 | External RAM output enable, active low, registered |
| ram_we_n | output | 1 | External RAM write enable, active low, registered |
| reg_rdata | output | 8 | Register file read data, registered |
| reg_rvalid | output | 1 | Register read data valid, registered |

## Verification
Every output of this block is due exactly one clock edge after the inputs that cause it: the three RAM strobes, the read data and the valid flag. Register writes land at that same edge and can be read back from the next access. The bench changes inputs on the falling edge and samples on the following falling edge, so each check sees the single registered response to one set of inputs. Sequences that span several edges are checked one cycle at a time: supply loss, recovery with chip enable held low, the idle edge that re-arms access, and the first enabled access after it.

// File: rtl/bbram_pkg.sv
package bbram_pkg;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

  function automatic strobe_t gate_strobe(input strobe_t h, input logic enable, input logic in_win);
    strobe_t s;
    s.ce_n = ~(enable & ~h.ce_n);
    s.oe_n = ~(enable & ~h.ce_n & ~h.oe_n & ~in_win);
    s.we_n = ~(enable & ~h.ce_n & ~h.we_n & ~in_win);
    return s;
  endfunction

endpackage

// File: rtl/bbram_window_dec.sv
module bbram_window_dec #(
  parameter int ADDR_W = 19,
  parameter int REG_AW = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [REG_AW-1:0] reg_idx
);
  localparam int WIN_W = ADDR_W - REG_AW;

  always_comb begin
    in_win  = &addr[ADDR_W-1 -: WIN_W];
    reg_idx = addr[REG_AW-1:0];
  end
endmodule

// File: rtl/bbram_supply_arm.sv
module bbram_supply_arm (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic host_ce_n,
  output logic enable
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst)              armed <= 1'b0;
    else if (!supply_ok)  armed <= 1'b0;
    else if (host_ce_n)   armed <= 1'b1;
  end

  always_comb enable = armed & supply_ok;
endmodule

// File: rtl/bbram_reg_bank.sv
module bbram_reg_bank #(
  parameter int DATA_W = 8,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << REG_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    rdata <= mem[idx];
  end
endmodule

// File: rtl/bbram_guard.sv
module bbram_guard #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ce_n,
  input  logic              host_we_n,
  input  logic              host_oe_n,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              supply_ok,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);
  import bbram_pkg::*;

  logic              in_win;
  logic [REG_AW-1:0] reg_idx;
  logic              enable;
  strobe_t           host_s;
  strobe_t           next_s;
  strobe_t           ram_q;
  logic              reg_wr;
  logic              reg_rd;

  bbram_window_dec #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_dec (
    .addr    (host_addr),
    .in_win  (in_win),
    .reg_idx (reg_idx)
  );

  bbram_supply_arm u_arm (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .host_ce_n (host_ce_n),
    .enable    (enable)
  );

  always_comb begin
    host_s = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};
    next_s = gate_strobe(host_s, enable, in_win);
    reg_wr = enable & in_win & ~host_ce_n & ~host_we_n;
    reg_rd = enable & in_win & ~host_ce_n & ~host_oe_n & host_we_n;
  end

  bbram_reg_bank #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk   (clk),
    .wr_en (reg_wr),
    .idx   (reg_idx),
    .wdata (host_wdata),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_q      <= STROBE_IDLE;
      reg_rvalid <= 1'b0;
    end else begin
      ram_q      <= next_s;
      reg_rvalid <= reg_rd;
    end
  end

  always_comb begin
    ram_ce_n = ram_q.ce_n;
    ram_oe_n = ram_q.oe_n;
    ram_we_n = ram_q.we_n;
  end
endmodule

// File: rtl/bbram_guard_chk.sv
module bbram_guard_chk #(
  parameter int ADDR_W = 19,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_ce_n,
  input logic              host_we_n,
  input logic              host_oe_n,
  input logic              supply_ok,
  input logic              ram_ce_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              reg_rvalid
);
  logic hit;
  always_comb hit = &host_addr[ADDR_W-1:REG_AW];

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ram_ce_n && ram_oe_n && ram_we_n && !reg_rvalid));

  p_window_no_oe_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && !host_ce_n) |=> ram_oe_n);

  p_window_no_we_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && !host_ce_n) |=> ram_we_n);

  p_rvalid_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (!hit || host_ce_n || host_oe_n || !host_we_n) |=> !reg_rvalid);

  p_supply_block_r7: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (ram_ce_n && ram_oe_n && ram_we_n && !reg_rvalid));

  p_rearm_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(supply_ok) |=> ram_ce_n);
endmodule

bind bbram_guard bbram_guard_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_ce_n  (host_ce_n),
  .host_we_n  (host_we_n),
  .host_oe_n  (host_oe_n),
  .supply_ok  (supply_ok),
  .ram_ce_n   (ram_ce_n),
  .ram_oe_n   (ram_oe_n),
  .ram_we_n   (ram_we_n),
  .reg_rvalid (reg_rvalid)
);

// File: tb/bbram_guard_tb.sv
`timescale 1ns/1ps
module bbram_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] host_addr = '0;
  logic        host_ce_n = 1'b1;
  logic        host_we_n = 1'b1;
  logic        host_oe_n = 1'b1;
  logic [7:0]  host_wdata = '0;
  logic        supply_ok = 1'b1;
  logic        ram_ce_n, ram_oe_n, ram_we_n;
  logic [7:0]  reg_rdata;
  logic        reg_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] shadow [16];

  always #2.5 clk = ~clk;

  bbram_guard u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_ce_n(host_ce_n),
    .host_we_n(host_we_n), .host_oe_n(host_oe_n), .host_wdata(host_wdata),
    .supply_ok(supply_ok), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [18:0] a, input logic ce, input logic we,
                     input logic oe, input logic [7:0] wd, input logic sup);
    host_addr = a; host_ce_n = ce; host_we_n = we; host_oe_n = oe;
    host_wdata = wd; supply_ok = sup;
    @(negedge clk);
  endtask

  task automatic strobes(input string req, input logic ce, input logic oe, input logic we);
    chk({req, " ce"}, {7'd0, ram_ce_n}, {7'd0, ce});
    chk({req, " oe"}, {7'd0, ram_oe_n}, {7'd0, oe});
    chk({req, " we"}, {7'd0, ram_we_n}, {7'd0, we});
  endtask

  initial begin
    logic [18:0] outs [4];
    outs[0] = 19'h00000; outs[1] = 19'h12345; outs[2] = 19'h7FFEF; outs[3] = 19'h3FFFF;
    repeat (3) @(negedge clk);
    strobes("R1 reset", 1, 1, 1);
    chk("R1 rvalid", {7'd0, reg_rvalid}, 8'd0);
    rst = 1'b0;
    cyc(19'h0, 1, 1, 1, 8'h0, 1);

    // R2 / R6: sweep every strobe combination outside the window
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 8; c++) begin
        cyc(outs[a], c[0], c[1], c[2], 8'h5A, 1);
        strobes("R2 pass", c[0], c[0] | c[2], c[0] | c[1]);
        chk("R6 no rvalid outside", {7'd0, reg_rvalid}, 8'd0);
      end

    // R5 / R10 / R3 / R4: write all sixteen registers
    for (int i = 0; i < 16; i++) begin
      shadow[i] = 8'((i * 29 + 7) & 8'hFF);
      cyc(19'h7FFF0 + 19'(i), 0, 0, 1, shadow[i], 1);
      strobes("R3 R4 window write", 0, 1, 1);
    end
    // R4: aliased writes outside the window must not touch registers
    for (int i = 0; i < 16; i++) begin
      cyc(19'h0FFF0 + 19'(i), 0, 0, 1, ~shadow[i], 1);
      strobes("R4 outside write reaches RAM", 0, 1, 0);
    end
    for (int i = 0; i < 16; i++) begin
      cyc(19'h7FFF0 + 19'(i), 0, 1, 0, 8'h0, 1);
      chk("R5 R10 readback", reg_rdata, shadow[i]);
      chk("R6 rvalid", {7'd0, reg_rvalid}, 8'd1);
      strobes("R3 window read", 0, 1, 1);
    end

    // R6: window without a full read strobe gives no valid
    cyc(19'h7FFF4, 1, 1, 0, 8'h0, 1);
    chk("R6 ce high", {7'd0, reg_rvalid}, 8'd0);
    cyc(19'h7FFF4, 0, 1, 1, 8'h0, 1);
    chk("R6 oe high", {7'd0, reg_rvalid}, 8'd0);

    // R7 / R8: supply loss
    cyc(19'h7FFF3, 0, 0, 1, 8'hAA, 0);
    strobes("R7 blocked write", 1, 1, 1);
    cyc(19'h01000, 0, 1, 0, 8'h0, 0);
    strobes("R7 blocked read", 1, 1, 1);
    cyc(19'h7FFF3, 0, 1, 0, 8'h0, 0);
    chk("R7 no rvalid", {7'd0, reg_rvalid}, 8'd0);
    // R9: supply back with chip enable still low
    cyc(19'h01000, 0, 1, 0, 8'h0, 1);
    strobes("R9 held after recovery", 1, 1, 1);
    cyc(19'h01000, 0, 0, 1, 8'h0, 1);
    strobes("R9 still held", 1, 1, 1);
    cyc(19'h01000, 1, 1, 1, 8'h0, 1);
    strobes("R9 idle edge", 1, 1, 1);
    cyc(19'h01000, 0, 1, 0, 8'h0, 1);
    strobes("R9 rearmed", 0, 0, 1);
    cyc(19'h7FFF3, 0, 1, 0, 8'h0, 1);
    chk("R8 write discarded", reg_rdata, shadow[3]);
    chk("R8 rvalid", {7'd0, reg_rvalid}, 8'd1);

    cyc(19'h0, 1, 1, 1, 8'h0, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule